// File: doc/BRIEF.md
# Dual-function PCI target decoder

This block is the target-side address decode for a device that appears on a PCI bus as two independent logical functions. Each function has its own IDSEL input, its own small configuration header and its own memory base register. The block captures each address phase, decides whether one of the two functions owns the cycle, and asserts DEVSEL# with medium decode timing. It then hands the selected back end a short description of the access: which function, configuration or memory, read or write, register half or DRAM half, and the 21-bit offset.

A memory cycle is owned by a function when address bits 31:22 equal that function's base field. That gives each function a 4 MB window. Bit 21 splits the window into a register half and a DRAM half. A configuration cycle is steered by IDSEL to the matching header. Writes to the header land in the data phase that completes, and the read data for the header is presented while the cycle is claimed. Master operation, arbitration, the DRAM controller and burst data movement are handled elsewhere.

Top module: `pci_dual_fn_decoder`

## Requirements
- R1: After reset, devsel_no is high, mem_en_o and master_en_o are all ones, and no base register is valid. The command dword (index 1) reads 0x0000_0006: bit 1 is memory enable and bit 2 is master enable.
- R2: A configuration command is claimed only when idsel_i has a bit asserted during the address phase. The commands are C/BE# 1010 for read and 1011 for write, with AD[1:0] = 00. The claimed function is the one whose idsel_i bit is set; function 0 wins if both bits are set, and the cycle is not claimed if neither is set.
- R3: The header dword is selected by AD[7:2]. Dword 0 reads {DEV_ID_BASE + fn, VEN_ID} and is read-only. In dword 1, bits 1 and 2 are writable, through byte lane 0. Dword 4 is the base register: bits 31:22 are writable and bits 21:0 read zero. Every other dword reads zero. In the data phase, byte enable C/BE#[k] low enables lane k, which is AD[8k+7:8k] (little-endian).
- R4: A memory command is claimed by function k when AD[31:22] equals the base field of k, k's base is valid and k's memory enable is set. The commands are C/BE# 0110 for read and 0111 for write. claim_write_o is C/BE#[0] of the command.
- R5: A function whose base register has never been written claims no memory cycle. Any configuration write to dword 4 with at least one byte enabled makes the base valid.
- R6: When both functions decode the same memory address, function 0 claims the cycle and function 1 does not.
- R7: For a claimed memory cycle, claim_dram_o equals AD[21] (1 = DRAM half, 0 = register half), and offset_o equals AD[20:0] of the address phase.
- R8: Commands other than memory read/write and configuration read/write never assert devsel_no.
- R9: If FRAME# is first sampled low at clock edge T0, devsel_no is high between T0 and T1 and is low from T1 onward.
- R10: devsel_no stays low through the non-final data phases. It goes high after the edge that samples FRAME# high with IRDY# and TRDY# both low.
- R11: A function whose memory enable is cleared claims no memory cycle, and its mem_en_o bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| trdy_ni | input | 1 | TRDY# as seen on the bus, active low |
| idsel_i | input | NUM_FN | Per-function configuration select |
| ad_i | input | 32 | Multiplexed address/data |
| cbe_ni | input | 4 | Command in address phase, active-low byte enables in data phase |
| devsel_no | output | 1 | DEVSEL#, active low |
| claim_fn_o | output | FN_W | Index of the claiming function |
| claim_cfg_o | output | 1 | Claimed cycle is a configuration access |
| claim_write_o | output | 1 | Claimed cycle is a write |
| claim_dram_o | output | 1 | Memory hit targets the DRAM half |
| offset_o | output | 21 | Offset within the half-window |
| cfg_rdata_o | output | 32 | Header read data of the claimed function |
| mem_en_o | output | NUM_FN | Memory enable per function |
| master_en_o | output | NUM_FN | Bus master enable per function |

## Verification
A base register whose valid flag or field is wrong shows up on the next memory cycle at that address. Within two clocks of the address phase, DEVSEL# either stays high or is asserted for the wrong function. A wrong priority between the functions also shows in claim_fn_o in that same cycle. A header register that keeps a bad value shows up the first time it is read back through a configuration read. An error in the DEVSEL# state is visible one clock early or late at the assertion edge or the release edge, so checking at both edges catches it within the same transaction.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  localparam int AD_W = 32;
  localparam int IDX_W = 6;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [IDX_W-1:0] IDX_ID  = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMD = 6'd1;
  localparam logic [IDX_W-1:0] IDX_BAR = 6'd4;

  function automatic logic is_mem(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

  function automatic logic is_cfg(input logic [3:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction
endpackage

// File: rtl/pci_addr_capture.sv
module pci_addr_capture
  import pci_dec_pkg::*;
#(
  parameter int NUM_FN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              busy_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [3:0]        cbe_ni,
  input  logic [NUM_FN-1:0] idsel_i,
  output logic              start_o,
  output logic              pend_o,
  output logic [AD_W-1:0]   addr_o,
  output logic [3:0]        cmd_o,
  output logic [NUM_FN-1:0] idsel_o
);
  logic frame_q;

  // address phase: first clock FRAME# low with the bus idle
  assign start_o = frame_q & ~frame_ni & irdy_ni & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b1;
      pend_o  <= 1'b0;
      addr_o  <= '0;
      cmd_o   <= '0;
      idsel_o <= '0;
    end else begin
      frame_q <= frame_ni;
      pend_o  <= start_o;
      if (start_o) begin
        addr_o  <= ad_i;
        cmd_o   <= cbe_ni;
        idsel_o <= idsel_i;
      end
    end
  end
endmodule

// File: rtl/pci_fn_cfg_hdr.sv
module pci_fn_cfg_hdr
  import pci_dec_pkg::*;
#(
  parameter logic [15:0] VEN_ID  = 16'h1A2B,
  parameter logic [15:0] DEV_ID  = 16'h0400,
  parameter int          WIN_LSB = 22,
  localparam int         BAR_W   = AD_W - WIN_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AD_W-1:0]  wdata_i,
  input  logic [3:0]       wbe_i,
  output logic [AD_W-1:0]  rdata_o,
  output logic [BAR_W-1:0] bar_o,
  output logic             bar_valid_o,
  output logic             mem_en_o,
  output logic             master_en_o
);
  logic [AD_W-1:0] bar_word;
  logic [AD_W-1:0] bar_merged;

  assign bar_word = {bar_o, {WIN_LSB{1'b0}}};

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      bar_merged[8*l +: 8] = wbe_i[l] ? wdata_i[8*l +: 8] : bar_word[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_o       <= '0;
      bar_valid_o <= 1'b0;
      mem_en_o    <= 1'b1;
      master_en_o <= 1'b1;
    end else if (wr_i) begin
      if (idx_i == IDX_BAR) begin
        bar_o <= bar_merged[AD_W-1:WIN_LSB];
        if (|wbe_i) bar_valid_o <= 1'b1;
      end
      if (idx_i == IDX_CMD && wbe_i[0]) begin
        mem_en_o    <= wdata_i[1];
        master_en_o <= wdata_i[2];
      end
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_ID:  rdata_o = {DEV_ID, VEN_ID};
      IDX_CMD: rdata_o = {29'd0, master_en_o, mem_en_o, 1'b0};
      IDX_BAR: rdata_o = bar_word;
      default: rdata_o = '0;
    endcase
  end

  AST_VALID_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bar_valid_o) |-> $past(wr_i) && $past(idx_i) == IDX_BAR); // R5
endmodule

// File: rtl/pci_fn_match.sv
module pci_fn_match
  import pci_dec_pkg::*;
#(
  parameter int  WIN_LSB = 22,
  localparam int BAR_W   = AD_W - WIN_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  addr_i,
  input  logic [3:0]       cmd_i,
  input  logic             idsel_i,
  input  logic [BAR_W-1:0] bar_i,
  input  logic             bar_valid_i,
  input  logic             mem_en_i,
  output logic             mem_hit_o,
  output logic             cfg_hit_o
);
  assign mem_hit_o = is_mem(cmd_i) & bar_valid_i & mem_en_i &
                     (addr_i[AD_W-1:WIN_LSB] == bar_i);
  // type 0 configuration only
  assign cfg_hit_o = is_cfg(cmd_i) & idsel_i & (addr_i[1:0] == 2'b00);

  AST_NO_HIT_UNWRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bar_valid_i |-> !mem_hit_o); // R5
  AST_NO_HIT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> !mem_hit_o); // R11
endmodule

// File: rtl/pci_target_sel.sv
module pci_target_sel
  import pci_dec_pkg::*;
#(
  parameter int  NUM_FN  = 2,
  parameter int  WIN_LSB = 22,
  localparam int OFF_W   = WIN_LSB - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic [NUM_FN-1:0] hit_i,
  input  logic [AD_W-1:0]   addr_i,
  input  logic [3:0]        cmd_i,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              trdy_ni,
  output logic [NUM_FN-1:0] claim_o,
  output logic              cfg_o,
  output logic              write_o,
  output logic              dram_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              xfer_o
);
  logic [NUM_FN-1:0] pick;
  logic              found;
  logic              last_done;

  // lowest index has priority
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_FN; k++) begin
      if (hit_i[k] && !found) begin
        pick[k] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign xfer_o    = (|claim_o) & ~irdy_ni & ~trdy_ni;
  assign last_done = xfer_o & frame_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_o <= '0;
      cfg_o   <= 1'b0;
      write_o <= 1'b0;
      dram_o  <= 1'b0;
      off_o   <= '0;
      idx_o   <= '0;
    end else if (pend_i) begin
      claim_o <= pick;
      cfg_o   <= is_cfg(cmd_i);
      write_o <= cmd_i[0];
      dram_o  <= addr_i[WIN_LSB-1];
      off_o   <= addr_i[OFF_W-1:0];
      idx_o   <= addr_i[IDX_W+1:2];
    end else if (last_done) begin
      claim_o <= '0;
    end
  end
endmodule

// File: rtl/pci_dual_fn_decoder.sv
module pci_dual_fn_decoder
  import pci_dec_pkg::*;
#(
  parameter int          NUM_FN      = 2,
  parameter int          WIN_LSB     = 22,
  parameter logic [15:0] VEN_ID      = 16'h1A2B,
  parameter logic [15:0] DEV_ID_BASE = 16'h0400,
  localparam int         OFF_W       = WIN_LSB - 1,
  localparam int         BAR_W       = AD_W - WIN_LSB,
  localparam int         FN_W        = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              trdy_ni,
  input  logic [NUM_FN-1:0] idsel_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [3:0]        cbe_ni,
  output logic              devsel_no,
  output logic [FN_W-1:0]   claim_fn_o,
  output logic              claim_cfg_o,
  output logic              claim_write_o,
  output logic              claim_dram_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic [AD_W-1:0]   cfg_rdata_o,
  output logic [NUM_FN-1:0] mem_en_o,
  output logic [NUM_FN-1:0] master_en_o
);
  logic              start_w, pend_w, xfer_w;
  logic [AD_W-1:0]   addr_w;
  logic [3:0]        cmd_w;
  logic [NUM_FN-1:0] idsel_w;
  logic [NUM_FN-1:0] mem_hit_w, cfg_hit_w, hit_w, claim_w, bar_valid_w;
  logic [IDX_W-1:0]  idx_w;
  logic [BAR_W-1:0]  bar_w   [NUM_FN];
  logic [AD_W-1:0]   rdata_w [NUM_FN];

  pci_addr_capture #(.NUM_FN(NUM_FN)) u_cap (
    .clk_i, .rst_ni, .frame_ni, .irdy_ni,
    .busy_i  (|claim_w),
    .ad_i, .cbe_ni, .idsel_i,
    .start_o (start_w),
    .pend_o  (pend_w),
    .addr_o  (addr_w),
    .cmd_o   (cmd_w),
    .idsel_o (idsel_w)
  );

  for (genvar k = 0; k < NUM_FN; k++) begin : g_fn
    pci_fn_cfg_hdr #(
      .VEN_ID  (VEN_ID),
      .DEV_ID  (DEV_ID_BASE + 16'(k)),
      .WIN_LSB (WIN_LSB)
    ) u_hdr (
      .clk_i, .rst_ni,
      .wr_i        (claim_w[k] & claim_cfg_o & claim_write_o & xfer_w),
      .idx_i       (idx_w),
      .wdata_i     (ad_i),
      .wbe_i       (~cbe_ni),
      .rdata_o     (rdata_w[k]),
      .bar_o       (bar_w[k]),
      .bar_valid_o (bar_valid_w[k]),
      .mem_en_o    (mem_en_o[k]),
      .master_en_o (master_en_o[k])
    );

    pci_fn_match #(.WIN_LSB(WIN_LSB)) u_match (
      .clk_i, .rst_ni,
      .addr_i      (addr_w),
      .cmd_i       (cmd_w),
      .idsel_i     (idsel_w[k]),
      .bar_i       (bar_w[k]),
      .bar_valid_i (bar_valid_w[k]),
      .mem_en_i    (mem_en_o[k]),
      .mem_hit_o   (mem_hit_w[k]),
      .cfg_hit_o   (cfg_hit_w[k])
    );

    assign hit_w[k] = mem_hit_w[k] | cfg_hit_w[k];

    AST_CFG_IDSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(claim_w[k]) && claim_cfg_o |-> $past(idsel_i[k], 2)); // R2
  end

  pci_target_sel #(.NUM_FN(NUM_FN), .WIN_LSB(WIN_LSB)) u_sel (
    .clk_i, .rst_ni,
    .pend_i   (pend_w),
    .hit_i    (hit_w),
    .addr_i   (addr_w),
    .cmd_i    (cmd_w),
    .frame_ni, .irdy_ni, .trdy_ni,
    .claim_o  (claim_w),
    .cfg_o    (claim_cfg_o),
    .write_o  (claim_write_o),
    .dram_o   (claim_dram_o),
    .off_o    (offset_o),
    .idx_o    (idx_w),
    .xfer_o   (xfer_w)
  );

  assign devsel_no = ~(|claim_w);

  always_comb begin
    claim_fn_o  = '0;
    cfg_rdata_o = '0;
    for (int k = 0; k < NUM_FN; k++) begin
      if (claim_w[k]) begin
        claim_fn_o = FN_W'(k);
        if (claim_cfg_o) cfg_rdata_o = rdata_w[k];
      end
    end
  end

  AST_MEDIUM_DEVSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |-> $past(start_w, 2)); // R9
  AST_RELEASE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !devsel_no && frame_ni && !irdy_ni && !trdy_ni |=> devsel_no); // R10
  AST_IGNORED_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w && !is_mem(cmd_w) && !is_cfg(cmd_w) |=> devsel_no); // R8

  if (NUM_FN > 1) begin : g_prio
    AST_OVERLAP_FN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_w && mem_hit_w[0] && mem_hit_w[1] |=> claim_w[0] && !claim_w[1]); // R6
  end
endmodule

// File: tb/pci_dual_fn_decoder_tb_top.sv
`timescale 1ns/1ps
module pci_dual_fn_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [1:0]  idsel = '0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '1;
  logic        devsel_n, c_cfg, c_wr, c_dram;
  logic [0:0]  c_fn;
  logic [20:0] off;
  logic [31:0] rdata;
  logic [1:0]  mem_en, mst_en;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model
  logic [9:0] m_bar [2];
  bit         m_val [2];
  bit         m_mem [2];
  bit         m_mst [2];

  always #2.5 clk = ~clk;

  pci_dual_fn_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .trdy_ni(trdy_n), .idsel_i(idsel), .ad_i(ad), .cbe_ni(cbe_n),
    .devsel_no(devsel_n), .claim_fn_o(c_fn), .claim_cfg_o(c_cfg),
    .claim_write_o(c_wr), .claim_dram_o(c_dram), .offset_o(off),
    .cfg_rdata_o(rdata), .mem_en_o(mem_en), .master_en_o(mst_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // returns {hit, fn}
  function automatic logic [1:0] exp_claim(input logic [3:0] cmd, input logic [31:0] a,
                                           input logic [1:0] ids);
    if ((cmd == 4'hA || cmd == 4'hB) && a[1:0] == 2'b00) begin
      if (ids[0]) return 2'b10;
      if (ids[1]) return 2'b11;
      return 2'b00;
    end
    if (cmd == 4'h6 || cmd == 4'h7) begin
      for (int k = 0; k < 2; k++)
        if (m_val[k] && m_mem[k] && a[31:22] == m_bar[k]) return {1'b1, 1'(k)};
    end
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_cfg(input int fn, input logic [5:0] idx);
    case (idx)
      6'd0: return {16'h0400 + 16'(fn), 16'h1A2B};
      6'd1: return {29'd0, m_mst[fn], m_mem[fn], 1'b0};
      6'd4: return {m_bar[fn], 22'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(input int fn, input logic [5:0] idx, input logic [31:0] d,
                             input logic [3:0] be);
    if (idx == 6'd4) begin
      if (be[2]) m_bar[fn][1:0] = d[23:22];
      if (be[3]) m_bar[fn][9:2] = d[31:24];
      if (|be) m_val[fn] = 1;
    end
    if (idx == 6'd1 && be[0]) begin
      m_mem[fn] = d[1];
      m_mst[fn] = d[2];
    end
  endtask

  task automatic bus_cycle(input string tag, input logic [3:0] cmd, input logic [31:0] a,
                           input logic [1:0] ids, input logic [31:0] wd,
                           input logic [3:0] be, input int nph);
    logic [1:0] e;
    e = exp_claim(cmd, a, ids);
    @(negedge clk);
    frame_n = 1'b0; ad = a; cbe_n = cmd; idsel = ids;
    @(posedge clk); @(negedge clk);
    check({tag, " R9 devsel high after address edge"}, 32'(devsel_n), 32'd1);
    ad = wd; cbe_n = ~be; irdy_n = 1'b0; idsel = '0; frame_n = (nph == 1);
    @(posedge clk); @(negedge clk);
    check({tag, " R9 devsel claim"}, 32'(devsel_n), 32'(!e[1]));
    if (!e[1]) begin
      irdy_n = 1'b1; frame_n = 1'b1;
      return;
    end
    check({tag, " fn"}, 32'(c_fn), 32'(e[0]));
    check({tag, " cfg"}, 32'(c_cfg), 32'(cmd[3]));
    check({tag, " R4 write"}, 32'(c_wr), 32'(cmd[0]));
    if (!cmd[3]) begin
      check({tag, " R7 dram"}, 32'(c_dram), 32'(a[21]));
      check({tag, " R7 offset"}, 32'(off), 32'(a[20:0]));
    end else if (!cmd[0]) begin
      check({tag, " R3 rdata"}, rdata, exp_cfg(int'(e[0]), a[7:2]));
    end
    trdy_n = 1'b0;
    for (int p = 1; p <= nph; p++) begin
      @(posedge clk); @(negedge clk);
      if (p < nph) begin
        check({tag, " R10 devsel held"}, 32'(devsel_n), 32'd0);
        frame_n = (p + 1 == nph);
      end
    end
    check({tag, " R10 devsel released"}, 32'(devsel_n), 32'd1);
    irdy_n = 1'b1; trdy_n = 1'b1;
    if (cmd == 4'hB) model_write(int'(e[0]), a[7:2], wd, be);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [3:0]  cmd;
    logic [31:0] seed;
    for (int k = 0; k < 2; k++) begin
      m_bar[k] = '0; m_val[k] = 0; m_mem[k] = 1; m_mst[k] = 1;
    end
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 devsel reset", 32'(devsel_n), 32'd1);
    check("R1 mem_en reset", 32'(mem_en), 32'd3);
    check("R1 master_en reset", 32'(mst_en), 32'd3);

    bus_cycle("R5 unwritten base", 4'h6, 32'h0000_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R2 id fn0", 4'hA, 32'h0000_0000, 2'b01, 0, 4'hF, 1);
    bus_cycle("R2 id fn1", 4'hA, 32'h0000_0000, 2'b10, 0, 4'hF, 1);
    bus_cycle("R2 both idsel", 4'hA, 32'h0000_0000, 2'b11, 0, 4'hF, 1);
    bus_cycle("R2 no idsel", 4'hA, 32'h0000_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R2 ad10 nonzero", 4'hA, 32'h0000_0001, 2'b01, 0, 4'hF, 1);
    bus_cycle("R1 cmd dword", 4'hA, 32'h0000_0004, 2'b01, 0, 4'hF, 1);
    bus_cycle("R3 id readonly wr", 4'hB, 32'h0000_0000, 2'b01, 32'hFFFF_FFFF, 4'hF, 1);
    bus_cycle("R3 id after wr", 4'hA, 32'h0000_0000, 2'b01, 0, 4'hF, 1);
    bus_cycle("R3 bar0 wr", 4'hB, 32'h0000_0010, 2'b01, 32'h124F_FFFF, 4'hF, 1);
    bus_cycle("R3 bar0 rd", 4'hA, 32'h0000_0010, 2'b01, 0, 4'hF, 1);
    bus_cycle("R3 bar1 lane3", 4'hB, 32'h0000_0010, 2'b10, 32'h80FF_FFFF, 4'b1000, 1);
    bus_cycle("R3 bar1 rd", 4'hA, 32'h0000_0010, 2'b10, 0, 4'hF, 1);
    bus_cycle("R7 fn0 dram", 4'h6, 32'h1260_0010, 2'b00, 0, 4'hF, 1);
    bus_cycle("R7 fn0 reg", 4'h7, 32'h1250_0ABC, 2'b00, 0, 4'hF, 1);
    bus_cycle("R4 fn1", 4'h6, 32'h803F_FFFF, 2'b00, 0, 4'hF, 1);
    bus_cycle("R4 miss", 4'h6, 32'h1200_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R8 io read", 4'h2, 32'h1240_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R8 mem read line", 4'hE, 32'h1240_0000, 2'b11, 0, 4'hF, 1);
    bus_cycle("R6 set overlap", 4'hB, 32'h0000_0010, 2'b10, 32'h1240_0000, 4'hF, 1);
    bus_cycle("R6 overlap fn0", 4'h6, 32'h1240_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R6 restore", 4'hB, 32'h0000_0010, 2'b10, 32'h8000_0000, 4'hF, 1);
    bus_cycle("R11 disable fn1", 4'hB, 32'h0000_0004, 2'b10, 32'h0000_0004, 4'h1, 1);
    check("R11 mem_en bit", 32'(mem_en), 32'd1);
    check("R11 master_en kept", 32'(mst_en), 32'd3);
    bus_cycle("R11 no claim", 4'h6, 32'h8000_0000, 2'b00, 0, 4'hF, 1);
    bus_cycle("R11 enable fn1", 4'hB, 32'h0000_0004, 2'b10, 32'h0000_0006, 4'h1, 1);
    bus_cycle("R10 burst fn1", 4'h7, 32'h8020_0100, 2'b00, 0, 4'hF, 3);
    bus_cycle("R10 burst fn0", 4'h6, 32'h1240_0000, 2'b00, 0, 4'hF, 4);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: cmd = 4'h6;
        3, 4:    cmd = 4'h7;
        5, 6, 7: cmd = 4'hA;
        8:       cmd = 4'h2;
        default: cmd = 4'hC;
      endcase
      a = $urandom;
      if (cmd == 4'hA) begin
        a[7:2] = 6'($urandom_range(0, 5));
        if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      end else if ($urandom_range(0, 2) != 0) begin
        a[31:22] = m_bar[$urandom_range(0, 1)];
      end
      bus_cycle("R4 random", cmd, a, 2'($urandom_range(0, 3)), $urandom, 4'hF,
                $urandom_range(1, 3));
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule